// File: doc/BRIEF.md
# Big-Endian Subword Data Memory

This block is a small byte-addressed memory, 1024 bytes by default, held as 32-bit words. Instructions and data share it. Each cycle it can take one request. A request carries an address, write data, an operation code and a size field. The operation code selects a word read, a word write or a subword write. Word writes and subword writes commit at the clock edge that takes the request. A read returns the addressed word one cycle later.

Alongside the full word, a read also returns a result sized for the core. This result holds a byte or a halfword, sign- or zero-extended to 32 bits. Byte lanes are numbered big-endian, so byte offset 0 is the most significant byte of the word. A subword write reads the addressed word, replaces only the target byte or halfword, and writes the merged word back. No byte enables are used. A halfword access at an odd address is flagged as misaligned, and such a request never modifies memory.

The bench loads initial contents through the normal write port.

Top module: `be_subword_mem`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_valid` and `rd_err` are 0, whatever request is presented.
- R2: A word write (`req_op`=1) stores `req_wdata` at the edge that takes it. A read (`req_op`=0) raises `rd_valid` in the next cycle only, and `rd_word` then holds the addressed word, including data written in the cycle just before.
- R3: Address bits [9:2] select the word. A word access ignores address bits [1:0].
- R4: Byte lanes are big-endian. Lane 0 is bits [31:24], lane 1 is [23:16], lane 2 is [15:8] and lane 3 is [7:0]. A byte read (`req_size`=0) returns the lane picked by address bits [1:0] in `rd_sub`.
- R5: A halfword read (`req_size`=1) returns bits [31:16] in `rd_sub` when address bit 1 is 0, and bits [15:0] when it is 1.
- R6: With `req_signed`=1, a byte or halfword result is sign-extended to 32 bits. With `req_signed`=0 it is zero-extended.
- R7: A subword write (`req_op`=2) replaces only the target lane and leaves every other byte of the word unchanged. A byte write takes `req_wdata[7:0]`, and a halfword write takes `req_wdata[15:0]`.
- R8: A halfword read or subword write with address bit 0 set raises `rd_err` in the next cycle and does not modify memory. On such a read, `rd_sub` is 0.
- R9: A size of 2 or 3 means a word. A read of that size returns `rd_sub` equal to `rd_word`, and a subword write of that size replaces the whole word.
- R10: A request with `req_valid`=0, or with `req_op`=3, modifies no memory and raises neither `rd_valid` nor `rd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 word write, 2 subword write, 3 no operation |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_signed | input | 1 | Sign-extend the sized read result |
| req_addr | input | ADDR_W (10) | Byte address |
| req_wdata | input | 32 | Write data, right-aligned for subword writes |
| rd_valid | output | 1 | Read result valid |
| rd_word | output | 32 | Full addressed word |
| rd_sub | output | 32 | Sized and extended read result |
| rd_err | output | 1 | Previous request was a misaligned halfword |

## Verification
A wrong lane order, or a merge that disturbs a neighbouring lane, shows at the ports on the next read of that word. That read returns a `rd_word` that differs from the bench model in a byte the write should not have touched, one cycle after the read request. A wrong extension choice shows on `rd_sub` in the same cycle as `rd_valid`. A misaligned request that writes memory anyway is exposed by the word read that follows it.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SUBW  = 2'd2,
    OP_IDLE  = 2'd3
  } op_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/bsm_word_store.sv
module bsm_word_store #(
  parameter int WADDR_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << WADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/bsm_lane_merge.sv
module bsm_lane_merge
  import bsm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          old_word,
  input  logic [DATA_W-1:0]          new_data,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [1:0]                 size,
  output logic [DATA_W-1:0]          merged
);
  localparam int NB = DATA_W / 8;
  localparam int LW = $clog2(NB);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * i;
    logic       hit;
    logic [7:0] src;

    always_comb begin
      if (size == SZ_BYTE) begin
        hit = (lane == LW'(i));
        src = new_data[7:0];
      end else if (size == SZ_HALF) begin
        hit = (lane[LW-1:1] == (LW-1)'(i / 2));
        src = (i % 2 == 0) ? new_data[15:8] : new_data[7:0];
      end else begin
        hit = 1'b1;
        src = new_data[HI -: 8];
      end
    end

    assign merged[HI -: 8] = hit ? src : old_word[HI -: 8];
  end
endmodule

// File: rtl/bsm_lane_extract.sv
module bsm_lane_extract
  import bsm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          word,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [1:0]                 size,
  input  logic                       sgn,
  output logic [DATA_W-1:0]          value
);
  localparam int NB = DATA_W / 8;
  localparam int LW = $clog2(NB);

  logic [DATA_W-1:0] byte_sh, half_sh;
  logic [7:0]        b;
  logic [15:0]       h;

  // Big-endian: lane L sits (NB-1-L) lanes above bit 0, i.e. ~L for power-of-two NB.
  assign byte_sh = word >> {~lane, 3'b000};
  assign half_sh = word >> {~lane[LW-1:1], 4'b0000};
  assign b = byte_sh[7:0];
  assign h = half_sh[15:0];

  always_comb begin
    if (size == SZ_BYTE)
      value = {{(DATA_W-8){sgn & b[7]}}, b};
    else if (size == SZ_HALF)
      value = {{(DATA_W-16){sgn & h[15]}}, h};
    else
      value = word;
  end
endmodule

// File: rtl/be_subword_mem.sv
module be_subword_mem
  import bsm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_word,
  output logic [31:0]       rd_sub,
  output logic              rd_err
);
  localparam int DATA_W  = 32;
  localparam int LW      = $clog2(DATA_W / 8);
  localparam int WADDR_W = ADDR_W - LW;

  logic [WADDR_W-1:0] widx;
  logic [LW-1:0]      lane;
  logic               is_read, is_wr, is_subw, misal, we;
  logic [DATA_W-1:0]  cur_word, merged, wr_word, sized;

  assign widx    = req_addr[ADDR_W-1:LW];
  assign lane    = req_addr[LW-1:0];
  assign is_read = req_valid && (req_op == OP_READ);
  assign is_wr   = req_valid && (req_op == OP_WRITE);
  assign is_subw = req_valid && (req_op == OP_SUBW);
  assign misal   = (is_read || is_subw) && (req_size == SZ_HALF) && req_addr[0];
  assign we      = is_wr || (is_subw && !misal);
  assign wr_word = is_wr ? req_wdata : merged;

  bsm_word_store #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (we),
    .addr  (widx),
    .wdata (wr_word),
    .rdata (cur_word)
  );

  bsm_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word (cur_word),
    .new_data (req_wdata),
    .lane     (lane),
    .size     (req_size),
    .merged   (merged)
  );

  bsm_lane_extract #(.DATA_W(DATA_W)) u_extract (
    .word  (cur_word),
    .lane  (lane),
    .size  (req_size),
    .sgn   (req_signed),
    .value (sized)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_word  <= '0;
      rd_sub   <= '0;
    end else begin
      rd_valid <= is_read;
      rd_err   <= misal;
      if (is_read) begin
        rd_word <= cur_word;
        rd_sub  <= misal ? '0 : sized;
      end
    end
  end
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker
  import bsm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [1:0]        req_size,
  input logic              req_signed,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rd_valid,
  input logic [31:0]       rd_word,
  input logic [31:0]       rd_sub,
  input logic              rd_err
);
  logic rd_req, odd_half;
  assign rd_req   = req_valid && (req_op == OP_READ);
  assign odd_half = req_valid && (req_op == OP_READ || req_op == OP_SUBW)
                    && (req_size == SZ_HALF) && req_addr[0];

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!rd_valid && !rd_err)); // R1
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) rd_req |=> rd_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !rd_req |=> !rd_valid); // R10
  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst) odd_half |=> rd_err); // R8
  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (rst) !odd_half |=> !rd_err); // R8
  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_valid && rd_err) |-> (rd_sub == 32'd0)); // R8
  AST_BYTE_EXT: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(req_size) == SZ_BYTE)
    |-> (rd_sub[31:8] == ($past(req_signed) ? {24{rd_sub[7]}} : 24'd0))); // R6
  AST_HALF_EXT: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_err && $past(req_size) == SZ_HALF)
    |-> (rd_sub[31:16] == ($past(req_signed) ? {16{rd_sub[15]}} : 16'd0))); // R6
  AST_WORD_SIZED: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(req_size[1])) |-> (rd_sub == rd_word)); // R9
endmodule

bind be_subword_mem bsm_checker #(.ADDR_W(ADDR_W)) u_bsm_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_size   (req_size),
  .req_signed (req_signed),
  .req_addr   (req_addr),
  .rd_valid   (rd_valid),
  .rd_word    (rd_word),
  .rd_sub     (rd_sub),
  .rd_err     (rd_err)
);

// File: tb/test_be_subword_mem.sv
`timescale 1ns/1ps
module test_be_subword_mem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd3;
  logic [1:0]  req_size = 2'd0;
  logic        req_signed = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid, rd_err;
  logic [31:0] rd_word, rd_sub;

  always #2.5 clk = ~clk;

  be_subword_mem #(.ADDR_W(10)) i_be_subword_mem (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_word(rd_word),
    .rd_sub(rd_sub), .rd_err(rd_err)
  );

  typedef struct {
    int          cyc;
    logic        v;
    logic        e;
    logic [31:0] w;
    logic [31:0] s;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] model [256];
  int          cyc = 0;
  int          nchk = 0;
  int          nbad = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] want_sub(logic [31:0] w, logic [9:0] a, logic [1:0] sz, logic sg);
    logic [7:0]  b;
    logic [15:0] h;
    if (sz == 2'd0) begin
      case (a[1:0])
        2'd0: b = w[31:24];
        2'd1: b = w[23:16];
        2'd2: b = w[15:8];
        default: b = w[7:0];
      endcase
      return sg ? {{24{b[7]}}, b} : {24'd0, b};
    end else if (sz == 2'd1) begin
      if (a[0]) return 32'd0;
      h = a[1] ? w[15:0] : w[31:16];
      return sg ? {{16{h[15]}}, h} : {16'd0, h};
    end
    return w;
  endfunction

  function automatic logic [31:0] want_merge(logic [31:0] w, logic [31:0] d, logic [9:0] a, logic [1:0] sz);
    logic [31:0] r;
    r = w;
    if (sz == 2'd0) begin
      case (a[1:0])
        2'd0: r[31:24] = d[7:0];
        2'd1: r[23:16] = d[7:0];
        2'd2: r[15:8]  = d[7:0];
        default: r[7:0] = d[7:0];
      endcase
    end else if (sz == 2'd1) begin
      if (a[1]) r[15:0] = d[15:0];
      else      r[31:16] = d[15:0];
    end else r = d;
    return r;
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Driver: applies one request per cycle at the falling edge and pushes its expectation.
  task automatic drive(logic v, logic [1:0] op, logic [1:0] sz, logic sg,
                       logic [9:0] a, logic [31:0] d, string tag);
    item_t it;
    logic  mis;
    logic [7:0] wi;
    wi  = a[9:2];
    mis = v && (op == 2'd0 || op == 2'd2) && sz == 2'd1 && a[0];
    it.cyc = cyc;
    it.tag = tag;
    it.v   = v && op == 2'd0;
    it.e   = mis;
    it.w   = model[wi];
    it.s   = want_sub(model[wi], a, sz, sg);
    if (v && op == 2'd1) model[wi] = d;
    if (v && op == 2'd2 && !mis) model[wi] = want_merge(model[wi], d, a, sz);
    req_valid = v; req_op = op; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = d;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compares each request's result one cycle after it was taken.
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].cyc != cyc) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, "rd_valid", {31'd0, rd_valid}, {31'd0, it.v});
      check(it.tag, "rd_err", {31'd0, rd_err}, {31'd0, it.e});
      if (it.v) begin
        check(it.tag, "rd_word", rd_word, it.w);
        check(it.tag, "rd_sub", rd_sub, it.s);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a misaligned read request
    req_valid = 1'b1; req_op = 2'd0; req_size = 2'd1; req_addr = 10'd1;
    repeat (3) @(negedge clk);
    check("R1", "rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    check("R1", "rd_err in reset", {31'd0, rd_err}, 32'd0);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check("R1", "rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    check("R1", "rd_err after reset", {31'd0, rd_err}, 32'd0);

    // R2 / R3: word writes with stray low address bits, then reads back
    for (int k = 0; k < 8; k++)
      drive(1, 2'd1, 2'd2, 0, 10'((k << 2) | (k & 3)), 32'h1357_9BDF ^ (32'h0101_0101 * k), "R3_wr");
    drive(1, 2'd1, 2'd2, 0, 10'h3FC, 32'hDEAD_BEEF, "R2_top");
    for (int k = 0; k < 8; k++)
      drive(1, 2'd0, 2'd2, 0, 10'((k << 2) | ((k + 1) & 3)), '0, "R3_rd");
    drive(1, 2'd0, 2'd3, 0, 10'h3FF, '0, "R2_top_rd");
    // R2: write immediately followed by read of the same word
    drive(1, 2'd1, 2'd2, 0, 10'h040, 32'h8A7F_C305, "R2_wr");
    drive(1, 2'd0, 2'd2, 0, 10'h040, '0, "R2_b2b");

    // R4 / R6: every byte lane, signed and unsigned
    for (int l = 0; l < 4; l++) begin
      drive(1, 2'd0, 2'd0, 1, 10'(10'h040 + l), '0, "R4_R6_bs");
      drive(1, 2'd0, 2'd0, 0, 10'(10'h040 + l), '0, "R4_R6_bu");
    end
    // R5 / R6: both halfword lanes
    for (int l = 0; l < 4; l += 2) begin
      drive(1, 2'd0, 2'd1, 1, 10'(10'h040 + l), '0, "R5_R6_hs");
      drive(1, 2'd0, 2'd1, 0, 10'(10'h040 + l), '0, "R5_R6_hu");
    end
    // R9: word-sized read
    drive(1, 2'd0, 2'd2, 1, 10'h042, '0, "R9_rd");

    // R8: misaligned halfword reads
    drive(1, 2'd0, 2'd1, 1, 10'h041, '0, "R8_rd1");
    drive(1, 2'd0, 2'd1, 0, 10'h043, '0, "R8_rd3");

    // R7: byte stores into each lane, checked by word read
    for (int l = 0; l < 4; l++) begin
      drive(1, 2'd2, 2'd0, 0, 10'(10'h080 + l), 32'hFFFF_FF00 | 32'(8'hA0 + l), "R7_sb");
      drive(1, 2'd0, 2'd2, 0, 10'h080, '0, "R7_sb_rd");
    end
    // R7: halfword stores
    drive(1, 2'd1, 2'd2, 0, 10'h084, 32'h0123_4567, "R7_init");
    drive(1, 2'd2, 2'd1, 0, 10'h086, 32'hFFFF_9ABC, "R7_sh_lo");
    drive(1, 2'd0, 2'd2, 0, 10'h084, '0, "R7_sh_rd");
    drive(1, 2'd2, 2'd1, 0, 10'h084, 32'h0000_F00D, "R7_sh_hi");
    drive(1, 2'd0, 2'd1, 1, 10'h084, '0, "R7_sh_rd2");

    // R8: misaligned halfword store leaves the word unchanged
    drive(1, 2'd2, 2'd1, 0, 10'h085, 32'h0000_5555, "R8_st");
    drive(1, 2'd0, 2'd2, 0, 10'h084, '0, "R8_st_rd");

    // R9: word-sized subword write replaces the whole word
    drive(1, 2'd2, 2'd3, 0, 10'h089, 32'hCAFE_F00D, "R9_st");
    drive(1, 2'd0, 2'd0, 1, 10'h08A, '0, "R9_st_rd");

    // R10: invalid request and no-op code touch nothing
    drive(0, 2'd1, 2'd2, 0, 10'h040, 32'h0, "R10_novalid");
    drive(1, 2'd3, 2'd1, 0, 10'h041, 32'h0, "R10_noop");
    drive(0, 2'd0, 2'd1, 0, 10'h041, 32'h0, "R10_noread");
    drive(1, 2'd0, 2'd2, 0, 10'h040, '0, "R10_rd");

    drive(0, 2'd3, 2'd0, 0, '0, '0, "idle");
    drive(0, 2'd3, 2'd0, 0, '0, '0, "idle");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule